// File: doc/BRIEF.md
# Daisy-Chained Input Serializer Reader

This block is an SPI master that reads a chain of N digital input serializers in one chip-select window and checks each one for faults. A one-cycle start pulse opens the transaction. The engine clocks out one byte per chip in narrow mode, or two bytes per chip in wide mode, where a status byte follows each input byte. Every received bit is kept in a frame register. When chip select has been released, a diagnostic slice per chip decodes that chip's bytes.

The results are registered together and announced by a one-cycle done pulse. They consist of a flat input vector with 8 bits per chip, a valid flag per chip, and one bit per chip for each of these flags: checksum mismatch, overtemperature, supply alarm, supply warning and external fault line. Only the chips that are faulting are withheld. Healthy chips in the same chain still return their data in the same read.

The fault line comes in one of two forms: a single line shared by the whole chain, or one line per chip. A configuration input selects the form. A second switch disregards all supply-related indications. This switch suits chains whose supply arrangement leaves the supply flags asserted all the time.

Top module: `serchain_reader`

## Requirements
- R1: A read keeps spi_cs_no low for one continuous window. In that window spi_sclk_o gives exactly 8·N rising edges when wide_mode_i=0, or 16·N when wide_mode_i=1. spi_sclk_o is low whenever spi_cs_no is high. MISO is sampled on rising edges, MSB first.
- R2: Bytes are numbered in order of reception, starting from 0. In wide mode, chip i's input byte is byte 2i and its status byte is byte 2i+1. In narrow mode, chip i's input byte is byte i. Bit k of chip i's input byte appears at data_o[8i+k].
- R3: In wide mode, crc_err_o[i] is set when status bits [7:3] differ from the 5-bit CRC of chip i's input byte. The CRC uses the polynomial x^5+x^4+x^2+1, starts from zero and takes the input byte MSB first.
- R4: In wide mode, ovt_o[i] equals status bit 1. uv_alarm_o[i] is set when status bit 2 is 0. uv_warn_o[i] is set when status bit 0 is 0.
- R5: While ignore_uv_i=1, uv_alarm_o, uv_warn_o and fault_o read 0, and none of those conditions makes a chip faulting.
- R6: With fault_shared_i=1, fault_i[0] applies to every chip. With fault_shared_i=0, fault_i[i] applies to chip i. fault_o[i] is the applicable line when ignore_uv_i=0.
- R7: In wide mode, a chip is faulting on fault_o, crc_err_o, ovt_o or uv_alarm_o. A supply warning on its own never makes a chip faulting.
- R8: In narrow mode, crc_err_o, ovt_o, uv_alarm_o and uv_warn_o read 0, and the fault line is the only cause of a faulting chip.
- R9: A faulting chip has valid_o[i]=0 and data_o[8i+7:8i]=0. Every other chip has valid_o[i]=1 and carries its input byte.
- R10: done_o is high for exactly one cycle. All result outputs take their new values in that cycle and hold them until the next done_o. A start_i pulse during a read is ignored. After reset, all result outputs are 0 and spi_cs_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin a read |
| wide_mode_i | input | 1 | 1: input byte plus status byte per chip; 0: input byte only |
| ignore_uv_i | input | 1 | Disregard supply flags and fault line |
| fault_shared_i | input | 1 | 1: fault_i[0] serves all chips |
| fault_i | input | N_CHIPS | Fault lines, high = fault |
| spi_miso_i | input | 1 | Serial data from the chain |
| spi_sclk_o | output | 1 | SPI clock, mode 0 |
| spi_cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse when results update |
| data_o | output | 8*N_CHIPS | Input bits, chip i at [8i+7:8i] |
| valid_o | output | N_CHIPS | Chip not faulting in last read |
| crc_err_o | output | N_CHIPS | Checksum mismatch per chip |
| ovt_o | output | N_CHIPS | Overtemperature per chip |
| uv_alarm_o | output | N_CHIPS | Supply alarm per chip |
| uv_warn_o | output | N_CHIPS | Supply warning per chip |
| fault_o | output | N_CHIPS | Applicable fault line per chip |

## Verification
The bench goes after three byte-order errors: swapping the input and status bytes, reversing the chain order, and reading narrow-mode bytes at wide-mode offsets. Any of these shows up as data landing on the wrong chip or as spurious checksum errors. It checks that a supply warning alone leaves the chip valid, and that the ignore switch masks the alarm, the warning and the fault line together. A design that treated the warning as a fault, or masked only some of these flags, would drop healthy chips or report flags that should be clear. The bench sets the shared and per-chip fault selections against each other, so a design that read the wrong fault line would invalidate the wrong chips. It also feeds garbage in the positions a narrow read never clocks, to show that narrow mode reports no status flags. A second start pulse during a read must not produce a second chip-select window.

// File: rtl/serchain_pkg.sv
package serchain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL, ST_EVAL
  } eng_state_e;

  localparam logic [7:0] CRC5_POLY_LJ = 8'hA8;  // x^5+x^4+x^2+1, left-justified

  function automatic logic [4:0] crc5_of(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ CRC5_POLY_LJ) : (r << 1);
    end
    return r[7:3];
  endfunction
endpackage

// File: rtl/serchain_spi_eng.sv
module serchain_spi_eng
  import serchain_pkg::*;
#(
  parameter int N_CHIPS = 4,
  parameter int CLK_DIV = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    wide_i,
  input  logic                    miso_i,
  output logic                    sclk_o,
  output logic                    cs_no,
  output logic                    busy_o,
  output logic                    eval_o,
  output logic                    wide_q_o,
  output logic [16*N_CHIPS-1:0]   frame_o
);
  localparam int FRAME_W = 16 * N_CHIPS;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int DIV_W   = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BITS_NAR  = BIT_W'(8 * N_CHIPS);
  localparam logic [BIT_W-1:0] BITS_WIDE = BIT_W'(FRAME_W);

  eng_state_e         state_q;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bits_q;
  logic               wide_q, sclk_q, cs_q;
  logic [FRAME_W-1:0] frame_q;
  logic               tick;
  logic [BIT_W-1:0]   target;

  assign tick   = (div_q == DIV_LAST);
  assign target = wide_q ? BITS_WIDE : BITS_NAR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      bits_q  <= '0;
      wide_q  <= 1'b0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      frame_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LEAD;
            cs_q    <= 1'b0;
            div_q   <= '0;
            bits_q  <= '0;
            wide_q  <= wide_i;
            frame_q <= '0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            div_q   <= '0;
            state_q <= ST_SHIFT;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            div_q <= '0;
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              frame_q <= {frame_q[FRAME_W-2:0], miso_i};
              bits_q  <= bits_q + 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bits_q == target) state_q <= ST_TAIL;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            div_q   <= '0;
            cs_q    <= 1'b1;
            state_q <= ST_EVAL;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        ST_EVAL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign cs_no    = cs_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign eval_o   = (state_q == ST_EVAL);
  assign wide_q_o = wide_q;
  assign frame_o  = frame_q;
endmodule

// File: rtl/serchain_chip_diag.sv
module serchain_chip_diag
  import serchain_pkg::*;
(
  input  logic [7:0] in_byte_i,
  input  logic [7:0] status_i,
  input  logic       wide_i,
  input  logic       ignore_uv_i,
  input  logic       fault_pin_i,
  output logic       crc_err_o,
  output logic       ovt_o,
  output logic       uv_alarm_o,
  output logic       uv_warn_o,
  output logic       fault_o,
  output logic       faulting_o
);
  logic [4:0] crc_calc;

  assign crc_calc   = crc5_of(in_byte_i);
  assign crc_err_o  = wide_i && (status_i[7:3] != crc_calc);
  assign ovt_o      = wide_i && status_i[1];
  assign uv_alarm_o = wide_i && !ignore_uv_i && !status_i[2];
  assign uv_warn_o  = wide_i && !ignore_uv_i && !status_i[0];
  assign fault_o    = fault_pin_i && !ignore_uv_i;
  // warning deliberately excluded
  assign faulting_o = fault_o || crc_err_o || ovt_o || uv_alarm_o;
endmodule

// File: rtl/serchain_reader.sv
module serchain_reader
  import serchain_pkg::*;
#(
  parameter int N_CHIPS = 4,
  parameter int CLK_DIV = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   wide_mode_i,
  input  logic                   ignore_uv_i,
  input  logic                   fault_shared_i,
  input  logic [N_CHIPS-1:0]     fault_i,
  input  logic                   spi_miso_i,
  output logic                   spi_sclk_o,
  output logic                   spi_cs_no,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [8*N_CHIPS-1:0]   data_o,
  output logic [N_CHIPS-1:0]     valid_o,
  output logic [N_CHIPS-1:0]     crc_err_o,
  output logic [N_CHIPS-1:0]     ovt_o,
  output logic [N_CHIPS-1:0]     uv_alarm_o,
  output logic [N_CHIPS-1:0]     uv_warn_o,
  output logic [N_CHIPS-1:0]     fault_o
);
  localparam int FRAME_W = 16 * N_CHIPS;

  logic               eval, wide_q;
  logic [FRAME_W-1:0] frame;

  serchain_spi_eng #(.N_CHIPS(N_CHIPS), .CLK_DIV(CLK_DIV)) eng_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .wide_i   (wide_mode_i),
    .miso_i   (spi_miso_i),
    .sclk_o   (spi_sclk_o),
    .cs_no    (spi_cs_no),
    .busy_o   (busy_o),
    .eval_o   (eval),
    .wide_q_o (wide_q),
    .frame_o  (frame)
  );

  logic [8*N_CHIPS-1:0] data_d;
  logic [N_CHIPS-1:0]   valid_d, crc_d, ovt_d, uva_d, uvw_d, flt_d;

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_chip
    // first received byte ends up in the most significant position
    localparam int IN_WIDE  = (2 * N_CHIPS - 1 - 2 * i) * 8;
    localparam int ST_WIDE  = (2 * N_CHIPS - 2 - 2 * i) * 8;
    localparam int IN_NAR   = (N_CHIPS - 1 - i) * 8;
    logic [7:0] in_byte, st_byte;
    logic       pin, faulting;

    assign in_byte = wide_q ? frame[IN_WIDE +: 8] : frame[IN_NAR +: 8];
    assign st_byte = frame[ST_WIDE +: 8];
    assign pin     = fault_shared_i ? fault_i[0] : fault_i[i];

    serchain_chip_diag diag_i (
      .in_byte_i   (in_byte),
      .status_i    (st_byte),
      .wide_i      (wide_q),
      .ignore_uv_i (ignore_uv_i),
      .fault_pin_i (pin),
      .crc_err_o   (crc_d[i]),
      .ovt_o       (ovt_d[i]),
      .uv_alarm_o  (uva_d[i]),
      .uv_warn_o   (uvw_d[i]),
      .fault_o     (flt_d[i]),
      .faulting_o  (faulting)
    );

    assign valid_d[i]         = !faulting;
    assign data_d[8*i +: 8]   = faulting ? 8'h00 : in_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      data_o     <= '0;
      valid_o    <= '0;
      crc_err_o  <= '0;
      ovt_o      <= '0;
      uv_alarm_o <= '0;
      uv_warn_o  <= '0;
      fault_o    <= '0;
    end else begin
      done_o <= eval;
      if (eval) begin
        data_o     <= data_d;
        valid_o    <= valid_d;
        crc_err_o  <= crc_d;
        ovt_o      <= ovt_d;
        uv_alarm_o <= uva_d;
        uv_warn_o  <= uvw_d;
        fault_o    <= flt_d;
      end
    end
  end
endmodule

// File: rtl/serchain_reader_chk.sv
module serchain_reader_chk #(
  parameter int N_CHIPS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wide_mode_i,
  input logic                 ignore_uv_i,
  input logic                 spi_sclk_o,
  input logic                 spi_cs_no,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [8*N_CHIPS-1:0] data_o,
  input logic [N_CHIPS-1:0]   valid_o,
  input logic [N_CHIPS-1:0]   crc_err_o,
  input logic [N_CHIPS-1:0]   ovt_o,
  input logic [N_CHIPS-1:0]   uv_alarm_o,
  input logic [N_CHIPS-1:0]   uv_warn_o,
  input logic [N_CHIPS-1:0]   fault_o
);
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (spi_cs_no && !spi_sclk_o)); // R1
  AST_SCLK_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !spi_cs_no); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_RESULTS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(data_o) && $stable(valid_o))); // R10
  AST_DONE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> spi_cs_no); // R10
  AST_FAULTING_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((crc_err_o | ovt_o | uv_alarm_o | fault_o) & valid_o) == '0); // R9
  AST_IGNORE_UV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ignore_uv_i)) |->
      (uv_alarm_o == '0 && uv_warn_o == '0 && fault_o == '0)); // R5
  AST_NARROW_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(wide_mode_i)) |->
      (crc_err_o == '0 && ovt_o == '0 && uv_alarm_o == '0 && uv_warn_o == '0)); // R8

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_zero
    AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o[i] |-> (data_o[8*i +: 8] == 8'h00)); // R9
  end
endmodule

bind serchain_reader serchain_reader_chk #(.N_CHIPS(N_CHIPS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wide_mode_i (wide_mode_i),
  .ignore_uv_i (ignore_uv_i),
  .spi_sclk_o  (spi_sclk_o),
  .spi_cs_no   (spi_cs_no),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .crc_err_o   (crc_err_o),
  .ovt_o       (ovt_o),
  .uv_alarm_o  (uv_alarm_o),
  .uv_warn_o   (uv_warn_o),
  .fault_o     (fault_o)
);

// File: tb/serchain_reader_tb_top.sv
`timescale 1ns/1ps
module serchain_reader_tb_top;
  localparam int NC  = 4;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wide = 1'b0, ign = 1'b0, shared = 1'b0;
  logic [NC-1:0] fault = '0;
  logic miso = 1'b0;
  logic sclk, cs_n, busy, done;
  logic [8*NC-1:0] data;
  logic [NC-1:0] valid, crc_e, ovt, uva, uvw, flt;

  always #10 clk = ~clk;

  serchain_reader #(.N_CHIPS(NC), .CLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_mode_i(wide),
    .ignore_uv_i(ign), .fault_shared_i(shared), .fault_i(fault),
    .spi_miso_i(miso), .spi_sclk_o(sclk), .spi_cs_no(cs_n), .busy_o(busy),
    .done_o(done), .data_o(data), .valid_o(valid), .crc_err_o(crc_e),
    .ovt_o(ovt), .uv_alarm_o(uva), .uv_warn_o(uvw), .fault_o(flt)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] tx_b [2*NC];
  logic [7:0] in_b [NC];
  logic [7:0] st_b [NC];
  int sidx = 0, rises = 0, cs_falls = 0;

  // serializer chain model: first bit valid at CS fall, next on each SCLK fall
  always @(negedge cs_n) begin
    sidx = 0;
    cs_falls++;
    miso = tx_b[0][7];
  end
  always @(negedge sclk) if (!cs_n) begin
    sidx++;
    if (sidx < 16*NC) miso = tx_b[sidx/8][7 - sidx%8];
  end
  always @(posedge sclk) if (!cs_n) rises++;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [4:0] c = 5'd0;
    logic fb;
    for (int b = 7; b >= 0; b--) begin
      fb = c[4] ^ d[b];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'h15;
    end
    return c;
  endfunction

  function automatic logic [7:0] good_st(input logic [7:0] d);
    return {ref_crc(d), 1'b1, 1'b0, 1'b1};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic do_read(input bit w, input bit iv, input bit sh,
                         input logic [NC-1:0] fv, input bit dbl_start);
    logic [8*NC-1:0] e_data;
    logic [NC-1:0] e_val, e_crc, e_ovt, e_uva, e_uvw, e_flt;
    int wait_n;
    bit got;
    for (int j = 0; j < 2*NC; j++) tx_b[j] = 8'h00;
    for (int i = 0; i < NC; i++) begin
      if (w) begin
        tx_b[2*i] = in_b[i];
        tx_b[2*i+1] = st_b[i];
      end else begin
        tx_b[i] = in_b[i];
        tx_b[NC+i] = 8'hFF ^ st_b[i];  // never clocked in narrow mode
      end
    end
    rises = 0;
    cs_falls = 0;
    @(negedge clk);
    wide = w; ign = iv; shared = sh; fault = fv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dbl_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    wait_n = 0;
    while (!got && wait_n < 5000) begin
      @(negedge clk);
      if (done) got = 1'b1;
      wait_n++;
    end
    if (!got) begin
      chk("R10", "done never seen", 0, 1);
      return;
    end
    for (int i = 0; i < NC; i++) begin
      logic pin, faulting;
      pin = sh ? fv[0] : fv[i];
      e_crc[i] = w && (st_b[i][7:3] != ref_crc(in_b[i]));
      e_ovt[i] = w && st_b[i][1];
      e_uva[i] = w && !iv && !st_b[i][2];
      e_uvw[i] = w && !iv && !st_b[i][0];
      e_flt[i] = pin && !iv;
      faulting = e_flt[i] | e_crc[i] | e_ovt[i] | e_uva[i];
      e_val[i] = !faulting;
      e_data[8*i +: 8] = faulting ? 8'h00 : in_b[i];
    end
    chk("R1", "sclk rising edges", rises, w ? 16*NC : 8*NC);
    chk("R10", "cs windows", cs_falls, 1);
    chk("R2", "data", data, e_data);
    chk("R9", "valid", valid, e_val);
    chk("R3", "crc_err", crc_e, e_crc);
    chk("R4", "ovt", ovt, e_ovt);
    chk("R4", "uv_alarm", uva, e_uva);
    chk("R4", "uv_warn", uvw, e_uvw);
    chk("R6", "fault", flt, e_flt);
    @(negedge clk);
    chk("R10", "done width", done, 0);
    chk("R10", "held data", data, e_data);
  endtask

  task automatic set_all_good();
    for (int i = 0; i < NC; i++) begin
      in_b[i] = 8'($urandom());
      st_b[i] = good_st(in_b[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    chk("R10", "reset data", data, 0);
    chk("R10", "reset valid", valid, 0);
    chk("R10", "reset cs_n", cs_n, 1);
    chk("R1", "reset sclk", sclk, 0);
    chk("R10", "reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // all healthy, wide
    in_b[0] = 8'h01; in_b[1] = 8'h80; in_b[2] = 8'hA5; in_b[3] = 8'h3C;
    for (int i = 0; i < NC; i++) st_b[i] = good_st(in_b[i]);
    do_read(1, 0, 0, '0, 0);
    // R3 checksum corrupted on chip 1
    set_all_good();
    st_b[1] = st_b[1] ^ 8'h08;
    do_read(1, 0, 0, '0, 0);
    // R4 overtemp chip 2, warning only on chip 0 (R7: chip 0 stays valid)
    set_all_good();
    st_b[2][1] = 1'b1;
    st_b[0][0] = 1'b0;
    do_read(1, 0, 0, '0, 0);
    // R7 supply alarm chip 3, then R5 same frame ignored
    set_all_good();
    st_b[3][2] = 1'b0;
    st_b[3][0] = 1'b0;
    do_read(1, 0, 0, '0, 0);
    do_read(1, 1, 0, 4'b1111, 0);
    // R6 shared fault line
    set_all_good();
    do_read(1, 0, 1, 4'b0001, 0);
    do_read(1, 0, 1, 4'b1110, 0);
    do_read(1, 1, 1, 4'b0001, 0);
    // R6 per-chip fault line
    do_read(1, 0, 0, 4'b0100, 0);
    // R8 narrow mode, status bytes garbage, fault on chip 1
    set_all_good();
    st_b[0] = 8'h00; st_b[2] = 8'h02;
    do_read(0, 0, 0, 4'b0010, 0);
    do_read(0, 0, 0, '0, 0);
    // R10 start during read ignored
    set_all_good();
    do_read(1, 0, 0, '0, 1);

    for (int n = 0; n < 24; n++) begin
      bit w, iv, sh;
      logic [NC-1:0] fv;
      w  = 1'($urandom_range(0, 1));
      iv = ($urandom_range(0, 3) == 0);
      sh = 1'($urandom_range(0, 1));
      for (int i = 0; i < NC; i++) begin
        fv[i] = ($urandom_range(0, 7) == 0);
        in_b[i] = 8'($urandom());
        st_b[i] = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : good_st(in_b[i]);
      end
      do_read(w, iv, sh, fv, 0);
    end
    finish_run();
  end
endmodule